// File: doc/BRIEF.md
# Character Blanking and Dimming Gate

This block decides, at every clock, whether the drivers of each character of a four-character LED display are lit. It combines several inputs. The first is an external active-low blank pin, which passes through a two-flop synchronizer. The second is a control register that holds a master blank bit, a bit that turns off the extended functions, and a 3-bit brightness code. The third is a one-bit hold-on flag for each character. The last is a pulse-width-modulated dimming wave produced inside the block.

Software writes the control register and the per-character attribute words through two synchronous write ports. These writes land at the next rising clock edge, whether or not the display is blanked at the time. The enable outputs are meant to gate the column drivers of a multiplexed display. The character storage, the font and the scanning all sit outside this block.

The internal dimming wave repeats every 30 clocks. Each brightness code sets a fixed number of lit steps in that period, spaced in a roughly geometric way from full brightness down to about 3 %.

Top module: `lamp_gate`

## Requirements
- R1: While rst_n is low, every char_en bit is 0. Reset clears the synchronizer and sets the extended-off bit, the master blank bit, the brightness code and all hold-on flags to 0. With blank_n_in held at 1, all four enables go high at the second rising edge after reset release and then stay high.
- R2: When the extended-off bit (control bit 6) is 1, every char_en bit equals the synchronized blank_n_in. The master blank bit and the hold-on flags have no effect.
- R3: When control bit 6 is 0, a character whose hold-on flag (attribute bit 1) is 0 is lit only while the synchronized blank_n_in is 1 and the master blank bit (control bit 2) is 0.
- R4: When control bit 6 is 0, a character whose hold-on flag is 1 is lit whatever blank_n_in and the master blank bit are, subject only to the dimming wave.
- R5: When control bit 6 is 0 and a character's blank decision is lit, that enable is high for exactly N clocks out of every 30 consecutive clocks. N depends on the brightness code held in control bits 5..3: code 0 gives 30, 1 gives 18, 2 gives 12, 3 gives 8, 4 gives 5, 5 gives 3, 6 gives 2 and 7 gives 1.
- R6: When control bit 6 is 1, the brightness code has no effect. A lit character stays lit for all 30 of every 30 clocks.
- R7: Characters held on by their hold-on flag are dimmed by the same wave as the other characters.
- R8: Control and attribute writes made while the display is blanked, whether by blank_n_in or by the master blank bit, are stored. Their effect becomes visible on char_en once the blanking is removed.
- R9: A change on blank_n_in reaches char_en at the second rising clock edge after the change, and not at the first.
- R10: A write through either port takes effect at the rising edge where the write strobe is sampled high. char_en shows the new value immediately after that edge.
- R11: Control bits 0, 1 and 7, and every attribute bit other than bit 1, have no effect on char_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control word (bit 6 extended-off, bits 5..3 brightness, bit 2 master blank) |
| attr_we | input | 1 | Attribute write strobe |
| attr_addr | input | 2 | Character index of the attribute write |
| attr_wdata | input | 8 | Attribute word (bit 1 hold-on flag) |
| blank_n_in | input | 1 | Asynchronous active-low external blank |
| char_en | output | 4 | Per-character driver enable |

## Verification
The bench attacks the points where blank sources interact. Hold-on characters must survive both the master blank and the external blank. A design that let either source win would darken a character that should stay lit. With the extended-off bit set, the bench checks that a master blank and a low brightness code are both ignored; a design that leaked either would dim or blank a display that should be fully on. It counts lit clocks over a full 30-clock window for every brightness code and for hold-on characters. An off-by-one compare or a mistyped step count would show up as a wrong count. It also checks the synchronizer latency exactly, and checks that writes made while blanked are stored, so that a design which dropped them or let blank_n_in act too early or too late is caught.

// File: rtl/lamp_gate_pkg.sv
package lamp_gate_pkg;

   localparam int unsigned BRT_W      = 3;
   localparam int unsigned NUM_LEVELS = 1 << BRT_W;

   typedef struct packed {
      logic             ext_off;
      logic             mblank;
      logic [BRT_W-1:0] brt;
   } ctrl_t;

   function automatic int unsigned level_pct(input int unsigned code);
      case (code)
         0:       return 100;
         1:       return 60;
         2:       return 40;
         3:       return 27;
         4:       return 17;
         5:       return 10;
         6:       return 7;
         default: return 3;
      endcase
   endfunction

   function automatic int unsigned level_steps(input int unsigned code,
                                               input int unsigned steps);
      int unsigned v;
      v = (level_pct(code) * steps + 50) / 100;
      if (v == 0) v = 1;
      return v;
   endfunction

endpackage

// File: rtl/lamp_bl_sync.sv
module lamp_bl_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= 1'b0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/lamp_ctrl_regs.sv
module lamp_ctrl_regs
   import lamp_gate_pkg::*;
#(
   parameter int unsigned NUM_CHARS = 4,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned EXT_BIT   = 6,
   parameter int unsigned MB_BIT    = 2,
   parameter int unsigned BRT_LSB   = 3,
   parameter int unsigned HOLD_BIT  = 1,
   localparam int unsigned ADDR_W   = (NUM_CHARS > 1) ? $clog2(NUM_CHARS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ctrl_we,
   input  logic [DATA_W-1:0]    ctrl_wdata,
   input  logic                 attr_we,
   input  logic [ADDR_W-1:0]    attr_addr,
   input  logic [DATA_W-1:0]    attr_wdata,
   output ctrl_t                ctrl_q,
   output logic [NUM_CHARS-1:0] hold_q
);
   localparam logic [DATA_W-1:0] CTRL_USED =
      (DATA_W'(1) << EXT_BIT) | (DATA_W'(1) << MB_BIT) |
      (DATA_W'((1 << BRT_W) - 1) << BRT_LSB);
   localparam logic [DATA_W-1:0] ATTR_USED = DATA_W'(1) << HOLD_BIT;

   logic unused_ctrl_bits;
   logic unused_attr_bits;
   assign unused_ctrl_bits = ^(ctrl_wdata & ~CTRL_USED);
   assign unused_attr_bits = ^(attr_wdata & ~ATTR_USED);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (ctrl_we) begin
         ctrl_q.ext_off <= ctrl_wdata[EXT_BIT];
         ctrl_q.mblank  <= ctrl_wdata[MB_BIT];
         ctrl_q.brt     <= ctrl_wdata[BRT_LSB +: BRT_W];
      end
   end

   generate
      for (genvar c = 0; c < NUM_CHARS; c++) begin : g_hold
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               hold_q[c] <= 1'b0;
            else if (attr_we && (attr_addr == ADDR_W'(c)))
               hold_q[c] <= attr_wdata[HOLD_BIT];
         end
      end
   endgenerate
endmodule

// File: rtl/lamp_pwm.sv
module lamp_pwm
   import lamp_gate_pkg::*;
#(
   parameter int unsigned STEPS = 30,
   localparam int unsigned CNT_W = $clog2(STEPS),
   localparam int unsigned LIM_W = $clog2(STEPS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bypass,
   input  logic [BRT_W-1:0] code,
   output logic [CNT_W-1:0] phase,
   output logic             wave_on
);
   logic [LIM_W-1:0] limit [NUM_LEVELS];

   generate
      for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lim
         assign limit[g] = LIM_W'(level_steps(g, STEPS));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             phase <= '0;
      else if (phase == CNT_W'(STEPS - 1))    phase <= '0;
      else                                    phase <= phase + 1'b1;
   end

   assign wave_on = bypass | (LIM_W'(phase) < limit[code]);
endmodule

// File: rtl/lamp_gate.sv
module lamp_gate
   import lamp_gate_pkg::*;
#(
   parameter int unsigned NUM_CHARS   = 4,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned EXT_BIT     = 6,
   parameter int unsigned MB_BIT      = 2,
   parameter int unsigned BRT_LSB     = 3,
   parameter int unsigned HOLD_BIT    = 1,
   parameter int unsigned PWM_STEPS   = 30,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 ctrl_we,
   input  logic [DATA_W-1:0]                    ctrl_wdata,
   input  logic                                 attr_we,
   input  logic [((NUM_CHARS > 1) ? $clog2(NUM_CHARS) : 1)-1:0] attr_addr,
   input  logic [DATA_W-1:0]                    attr_wdata,
   input  logic                                 blank_n_in,
   output logic [NUM_CHARS-1:0]                 char_en
);
   localparam int unsigned CNT_W = $clog2(PWM_STEPS);

   generate
      if (EXT_BIT >= DATA_W || MB_BIT >= DATA_W || HOLD_BIT >= DATA_W ||
          BRT_LSB + BRT_W > DATA_W) begin : g_bad_field
         $error("lamp_gate: a control or attribute field lies outside DATA_W");
      end
      if (PWM_STEPS < 2) begin : g_bad_steps
         $error("lamp_gate: PWM_STEPS must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("lamp_gate: SYNC_STAGES must be at least 2");
      end
      if (NUM_CHARS < 1) begin : g_bad_chars
         $error("lamp_gate: NUM_CHARS must be at least 1");
      end
   endgenerate

   ctrl_t                ctrl_q;
   logic [NUM_CHARS-1:0] hold_q;
   logic                 bl_sync;
   logic [CNT_W-1:0]     pwm_phase;
   logic                 pwm_on;
   logic [NUM_CHARS-1:0] lit_dec;

   lamp_ctrl_regs #(
      .NUM_CHARS (NUM_CHARS),
      .DATA_W    (DATA_W),
      .EXT_BIT   (EXT_BIT),
      .MB_BIT    (MB_BIT),
      .BRT_LSB   (BRT_LSB),
      .HOLD_BIT  (HOLD_BIT)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl_we    (ctrl_we),
      .ctrl_wdata (ctrl_wdata),
      .attr_we    (attr_we),
      .attr_addr  (attr_addr),
      .attr_wdata (attr_wdata),
      .ctrl_q     (ctrl_q),
      .hold_q     (hold_q)
   );

   lamp_bl_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (blank_n_in),
      .q_sync  (bl_sync)
   );

   lamp_pwm #(
      .STEPS (PWM_STEPS)
   ) u_pwm (
      .clk     (clk),
      .rst_n   (rst_n),
      .bypass  (ctrl_q.ext_off),
      .code    (ctrl_q.brt),
      .phase   (pwm_phase),
      .wave_on (pwm_on)
   );

   generate
      for (genvar c = 0; c < NUM_CHARS; c++) begin : g_char
         always_comb begin
            if (ctrl_q.ext_off) lit_dec[c] = bl_sync;
            else                lit_dec[c] = hold_q[c] | (bl_sync & ~ctrl_q.mblank);
         end
         assign char_en[c] = lit_dec[c] & pwm_on;
      end
   endgenerate
endmodule

// File: rtl/lamp_gate_chk.sv
module lamp_gate_chk #(
   parameter int unsigned NUM_CHARS = 4,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned EXT_BIT   = 6,
   parameter int unsigned MB_BIT    = 2,
   parameter int unsigned PWM_STEPS = 30,
   localparam int unsigned CNT_W    = $clog2(PWM_STEPS)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 ctrl_we,
   input logic [DATA_W-1:0]    ctrl_wdata,
   input logic                 blank_n_in,
   input logic [NUM_CHARS-1:0] char_en,
   input logic                 ext_off,
   input logic                 mblank,
   input logic [NUM_CHARS-1:0] hold,
   input logic                 bl_sync,
   input logic                 pwm_on,
   input logic [CNT_W-1:0]     phase
);
   logic [1:0] run_cyc;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               run_cyc <= '0;
      else if (run_cyc != 2'd3) run_cyc <= run_cyc + 1'b1;
   end

   assert_reset_dark_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> char_en == '0);

   assert_ext_blank_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_off && !bl_sync) |-> char_en == '0);

   assert_ext_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_off && bl_sync) |-> char_en == '1);

   assert_mblank_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_off && mblank) |-> (char_en & ~hold) == '0);

   generate
      for (genvar c = 0; c < NUM_CHARS; c++) begin : g_hold_chk
         assert_hold_lit_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!ext_off && hold[c] && pwm_on) |-> char_en[c]);
      end
   endgenerate

   assert_sync_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (run_cyc >= 2'd2) |-> bl_sync == $past(blank_n_in, 2));

   assert_phase_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      phase < CNT_W'(PWM_STEPS));

   assert_ctrl_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_we |=> (ext_off == $past(ctrl_wdata[EXT_BIT]) &&
                   mblank  == $past(ctrl_wdata[MB_BIT])));
endmodule

bind lamp_gate lamp_gate_chk #(
   .NUM_CHARS (NUM_CHARS),
   .DATA_W    (DATA_W),
   .EXT_BIT   (EXT_BIT),
   .MB_BIT    (MB_BIT),
   .PWM_STEPS (PWM_STEPS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ctrl_we    (ctrl_we),
   .ctrl_wdata (ctrl_wdata),
   .blank_n_in (blank_n_in),
   .char_en    (char_en),
   .ext_off    (ctrl_q.ext_off),
   .mblank     (ctrl_q.mblank),
   .hold       (hold_q),
   .bl_sync    (bl_sync),
   .pwm_on     (pwm_on),
   .phase      (pwm_phase)
);

// File: tb/lamp_gate_bench.sv
module lamp_gate_bench;
   localparam int NCH   = 4;
   localparam int STEPS = 30;
   localparam int WD_LIMIT = 20000;
   localparam int EXP_ON [8] = '{30, 18, 12, 8, 5, 3, 2, 1};

   // {ext_off, mblank, hold[3:0], blank_n, expected[3:0]} with brightness code 0
   localparam logic [10:0] VEC [8] = '{
      {1'b0, 1'b0, 4'b0000, 1'b1, 4'b1111},
      {1'b0, 1'b0, 4'b0000, 1'b0, 4'b0000},
      {1'b0, 1'b1, 4'b0000, 1'b1, 4'b0000},
      {1'b0, 1'b1, 4'b0101, 1'b1, 4'b0101},
      {1'b0, 1'b0, 4'b1010, 1'b0, 4'b1010},
      {1'b1, 1'b1, 4'b0000, 1'b1, 4'b1111},
      {1'b1, 1'b0, 4'b1111, 1'b0, 4'b0000},
      {1'b0, 1'b1, 4'b1001, 1'b0, 4'b1001}
   };

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           ctrl_we = 1'b0;
   logic [7:0]     ctrl_wdata = '0;
   logic           attr_we = 1'b0;
   logic [1:0]     attr_addr = '0;
   logic [7:0]     attr_wdata = '0;
   logic           blank_n_in = 1'b1;
   logic [NCH-1:0] char_en;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;
   int win_cnt [NCH];

   always #10 clk = ~clk;

   lamp_gate u_lamp_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl_we    (ctrl_we),
      .ctrl_wdata (ctrl_wdata),
      .attr_we    (attr_we),
      .attr_addr  (attr_addr),
      .attr_wdata (attr_wdata),
      .blank_n_in (blank_n_in),
      .char_en    (char_en)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > WD_LIMIT) begin
         checks = checks + 1;
         errors = errors + 1;
         $display("FAIL watchdog R9: cycles=%0d expected below %0d", cyc, WD_LIMIT);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input int act, input int exp, input string req);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr_ctrl(input logic ext, input logic mb, input logic [2:0] code,
                          input logic [2:0] junk);
      ctrl_wdata = {junk[2], ext, code, mb, junk[1:0]};
      ctrl_we    = 1'b1;
      @(posedge clk);
      @(negedge clk);
      ctrl_we    = 1'b0;
   endtask

   task automatic wr_attr(input int idx, input logic hold, input logic [6:0] junk);
      attr_addr  = 2'(idx);
      attr_wdata = {junk[6:1], hold, junk[0]};
      attr_we    = 1'b1;
      @(posedge clk);
      @(negedge clk);
      attr_we    = 1'b0;
   endtask

   task automatic wr_holds(input logic [NCH-1:0] h);
      for (int i = 0; i < NCH; i++) wr_attr(i, h[i], 7'd0);
   endtask

   task automatic set_bl(input logic v);
      blank_n_in = v;
      repeat (2) @(negedge clk);
   endtask

   task automatic count_window();
      for (int i = 0; i < NCH; i++) win_cnt[i] = 0;
      for (int t = 0; t < STEPS; t++) begin
         for (int i = 0; i < NCH; i++) win_cnt[i] += int'(char_en[i]);
         @(negedge clk);
      end
   endtask

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(int'(char_en), 0, "R1 enables low in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk(int'(char_en), 0, "R9 one edge after release still dark");
      @(negedge clk);
      chk(int'(char_en), 15, "R1 all lit after reset");
      count_window();
      for (int i = 0; i < NCH; i++) chk(win_cnt[i], 30, "R1 full brightness from reset");

      // R9: sync latency on falling and rising blank
      blank_n_in = 1'b0;
      @(negedge clk);
      chk(int'(char_en), 15, "R9 blank not yet seen after one edge");
      @(negedge clk);
      chk(int'(char_en), 0, "R9 blank seen after two edges");
      blank_n_in = 1'b1;
      @(negedge clk);
      chk(int'(char_en), 0, "R9 release not yet seen after one edge");
      @(negedge clk);
      chk(int'(char_en), 15, "R9 release seen after two edges");

      // R2 R3 R4: table of blank combinations
      for (int v = 0; v < 8; v++) begin
         wr_ctrl(VEC[v][10], VEC[v][9], 3'd0, 3'd0);
         wr_holds(VEC[v][8:5]);
         set_bl(VEC[v][4]);
         chk(int'(char_en), int'(VEC[v][3:0]),
             VEC[v][10] ? "R2 ext-off follows blank pin" : "R3/R4 blank combination");
      end

      // R5: every brightness code, all chars lit
      wr_holds(4'b0000);
      set_bl(1'b1);
      for (int code = 0; code < 8; code++) begin
         wr_ctrl(1'b0, 1'b0, 3'(code), 3'd0);
         count_window();
         for (int i = 0; i < NCH; i++) chk(win_cnt[i], EXP_ON[code], "R5 lit steps per code");
      end

      // R7: held chars dimmed under master blank
      wr_holds(4'b0110);
      wr_ctrl(1'b0, 1'b1, 3'd5, 3'd0);
      count_window();
      chk(win_cnt[0], 0, "R7 unheld char dark");
      chk(win_cnt[1], 3, "R7 held char dimmed");
      chk(win_cnt[2], 3, "R7 held char dimmed");
      chk(win_cnt[3], 0, "R7 unheld char dark");

      // R6: ext-off ignores brightness code
      wr_ctrl(1'b1, 1'b1, 3'd7, 3'd0);
      count_window();
      for (int i = 0; i < NCH; i++) chk(win_cnt[i], 30, "R6 code ignored with ext-off");

      // R10: write timing
      wr_holds(4'b0000);
      wr_ctrl(1'b0, 1'b0, 3'd0, 3'd0);
      chk(int'(char_en), 15, "R10 unblank visible right after write edge");
      ctrl_wdata = 8'h04;
      ctrl_we    = 1'b1;
      #1;
      chk(int'(char_en), 15, "R10 no effect before write edge");
      @(posedge clk);
      @(negedge clk);
      ctrl_we = 1'b0;
      chk(int'(char_en), 0, "R10 master blank after write edge");
      wr_attr(3, 1'b1, 7'd0);
      chk(int'(char_en), 8, "R10 attribute write visible after edge");

      // R8: writes stored while blanked
      wr_holds(4'b0000);
      set_bl(1'b0);
      wr_ctrl(1'b0, 1'b0, 3'd2, 3'd0);
      wr_attr(2, 1'b1, 7'd0);
      count_window();
      chk(win_cnt[2], 12, "R8 held char write and code stored while blanked");
      chk(win_cnt[0], 0, "R8 unheld char still blanked");
      wr_ctrl(1'b0, 1'b1, 3'd4, 3'd0);
      wr_attr(2, 1'b0, 7'd0);
      set_bl(1'b1);
      chk(int'(char_en), 0, "R8 master blank written while blanked holds");
      wr_ctrl(1'b0, 1'b0, 3'd4, 3'd0);
      count_window();
      for (int i = 0; i < NCH; i++) chk(win_cnt[i], 5, "R8 code stored during blank");

      // R11: stray bits ignored
      wr_ctrl(1'b0, 1'b0, 3'd0, 3'b111);
      for (int i = 0; i < NCH; i++) wr_attr(i, 1'b0, 7'h7F);
      count_window();
      for (int i = 0; i < NCH; i++) chk(win_cnt[i], 30, "R11 stray control bits ignored");
      set_bl(1'b0);
      chk(int'(char_en), 0, "R11 stray attribute bits do not hold chars on");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule